// File: doc/BRIEF.md
# Differential PSK Bit Recovery with Self-Synchronising Descrambler

This block converts a stream of received symbol phases into descrambled data bits for differential BPSK and differential QPSK. Each input symbol carries a 2-bit quadrant code: 0 is 0 degrees, 1 is +90, 2 is 180 and 3 is -90, counted counterclockwise. The block subtracts the previous quadrant from the new one. In QPSK mode it maps that change to a two-bit pair. In BPSK mode it maps the change to one bit. The bits go out serially, earliest first, through a 7-stage self-synchronising descrambler.

A start strobe begins a new packet. After the strobe, the first accepted symbol only sets the phase reference. Both stream interfaces use valid/ready. A symbol is taken on a clock edge where `sym_valid_i` and `sym_ready_o` are both high. A bit is delivered on an edge where `bit_valid_o` and `bit_ready_i` are both high. `sym_ready_o` stays low while any bit of the previous symbol is still pending, and while `start_i` is high. While `bit_ready_i` is low, `bit_valid_o` and `bit_data_o` keep their values. The upstream source may hold `sym_valid_i` high for as long as needed. The sink may stall for any number of cycles.

Top module: `dpsk_bit_recover`

## Requirements
- R1: In QPSK mode (`mode_qpsk_i`=1), with delta = (new quadrant - previous quadrant) mod 4, each symbol emits two bits: delta 0 gives 00, delta 1 gives 01, delta 2 gives 11 and delta 3 gives 10.
- R2: Of the two bits in R1, the left one is emitted first.
- R3: When `rot_rev_i`=1, delta is taken as (previous quadrant - new quadrant) mod 4.
- R4: In BPSK mode (`mode_qpsk_i`=0), each symbol emits one bit: 0 for delta 0 and 1 for delta 2.
- R5: In BPSK mode, an odd delta sets `odd_err_o`. It still emits one bit, equal to bit 1 of delta. The flag stays set until the next `start_i`.
- R6: After reset or `start_i`, the first accepted symbol emits no bits and only sets the reference.
- R7: Output bit n equals r(n) XOR r(n-4) XOR r(n-7). Here r is the decoded bit sequence since the last start or reset, and r(k)=0 for k<0.
- R8: Flipping a single decoded bit at position k changes exactly the output bits k, k+4 and k+7.
- R9: `sym_ready_o` is high only when no bit is pending. While `bit_ready_i` is low, `bit_valid_o` and `bit_data_o` hold.
- R10: `start_i` takes precedence over everything else. It discards pending bits, clears the descrambler history, the reference and `odd_err_o`, and holds `sym_ready_o` low.
- R11: After reset, `bit_valid_o`=0, `odd_err_o`=0 and `sym_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Packet start strobe |
| mode_qpsk_i | input | 1 | 1 selects differential QPSK, 0 selects differential BPSK |
| rot_rev_i | input | 1 | Reverses the sense of positive rotation |
| sym_valid_i | input | 1 | Symbol valid |
| sym_phase_i | input | 2 | Quadrant code of the symbol |
| sym_ready_o | output | 1 | Block can take a symbol |
| bit_valid_o | output | 1 | Output bit valid |
| bit_data_o | output | 1 | Descrambled output bit |
| bit_ready_i | input | 1 | Sink can take a bit |
| odd_err_o | output | 1 | Sticky flag: odd phase change seen in BPSK mode |

## Verification
The assertions assume that every input changes only between clock edges. They also assume that the mode and rotation inputs are stable while a symbol is offered, because the odd-change check reads the mode together with the accepted phase. The bench drives every input on the falling edge. It changes mode and rotation only before a start strobe, and it pulses `start_i` only when no bits are pending, except in the one scenario that deliberately discards pending bits. Under these conditions, each transfer the bench records is the one the design saw at the rising edge.

// File: rtl/dpsk_pkg.sv
package dpsk_pkg;
  typedef enum logic {
    MODE_DBPSK = 1'b0,
    MODE_DQPSK = 1'b1
  } dpsk_mode_e;

  localparam int QUAD_W = 2;

  // Phase change (in quadrants) to bit pair; bit 1 of the result goes out first.
  function automatic logic [1:0] quad_to_pair(input logic [QUAD_W-1:0] d);
    return {d[1], d[1] ^ d[0]};
  endfunction
endpackage

// File: rtl/dpsk_phase_tracker.sv
module dpsk_phase_tracker #(
  parameter int QW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic          rot_rev,
  input  logic [QW-1:0] phase,
  output logic [QW-1:0] delta,
  output logic          have_ref
);
  logic [QW-1:0] prev_q;
  logic          ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      ref_q  <= 1'b0;
    end else if (clr) begin
      ref_q  <= 1'b0;
    end else if (take) begin
      prev_q <= phase;
      ref_q  <= 1'b1;
    end
  end

  // Modulo arithmetic wraps naturally at QW bits.
  always_comb begin
    if (rot_rev) delta = prev_q - phase;
    else         delta = phase - prev_q;
  end

  assign have_ref = ref_q;
endmodule

// File: rtl/dpsk_serializer.sv
module dpsk_serializer #(
  parameter  int MAXB = 2,
  localparam int CW   = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [MAXB-1:0] bits,
  input  logic [CW-1:0]   nbits,
  input  logic            pop,
  output logic            head,
  output logic            busy
);
  logic [MAXB-1:0] sh_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= bits;
      cnt_q <= nbits;
    end else if (pop && cnt_q != '0) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign head = sh_q[MAXB-1];
  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpsk_descrambler.sv
module dpsk_descrambler #(
  parameter int LEN   = 7,
  parameter int TAP_A = 4,
  parameter int TAP_B = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;

  // Stage 0 holds the newest received bit; stage i is i+1 bits old.
  for (genvar i = 0; i < LEN; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n || clr) hist[i] <= 1'b0;
      else if (shift)    hist[i] <= (i == 0) ? din : hist[(i == 0) ? 0 : i-1];
    end
  end

  assign dout = din ^ hist[TAP_A-1] ^ hist[TAP_B-1];
endmodule

// File: rtl/dpsk_bit_recover.sv
module dpsk_bit_recover #(
  parameter int SCR_LEN  = 7,
  parameter int TAP_NEAR = 4,
  parameter int TAP_FAR  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       mode_qpsk_i,
  input  logic       rot_rev_i,
  input  logic       sym_valid_i,
  input  logic [1:0] sym_phase_i,
  output logic       sym_ready_o,
  output logic       bit_valid_o,
  output logic       bit_data_o,
  input  logic       bit_ready_i,
  output logic       odd_err_o
);
  import dpsk_pkg::*;

  localparam int MAXB = 2;
  localparam int CW   = $clog2(MAXB + 1);

  dpsk_mode_e        mode;
  logic [QUAD_W-1:0] delta;
  logic              have_ref;
  logic              busy;
  logic              take;
  logic              load;
  logic              pop;
  logic              head;
  logic [MAXB-1:0]   load_bits;
  logic [CW-1:0]     load_n;
  logic              err_q;

  assign mode        = dpsk_mode_e'(mode_qpsk_i);
  assign sym_ready_o = !busy && !start_i;
  assign take        = sym_valid_i && sym_ready_o;
  assign load        = take && have_ref;
  assign pop         = bit_valid_o && bit_ready_i;
  assign bit_valid_o = busy;

  always_comb begin
    if (mode == MODE_DQPSK) begin
      load_bits = quad_to_pair(delta);
      load_n    = CW'(2);
    end else begin
      load_bits = {delta[1], 1'b0};
      load_n    = CW'(1);
    end
  end

  dpsk_phase_tracker #(.QW(QUAD_W)) trk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_i),
    .take     (take),
    .rot_rev  (rot_rev_i),
    .phase    (sym_phase_i),
    .delta    (delta),
    .have_ref (have_ref)
  );

  dpsk_serializer #(.MAXB(MAXB)) ser_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_i),
    .load  (load),
    .bits  (load_bits),
    .nbits (load_n),
    .pop   (pop),
    .head  (head),
    .busy  (busy)
  );

  dpsk_descrambler #(.LEN(SCR_LEN), .TAP_A(TAP_NEAR), .TAP_B(TAP_FAR)) dsc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_i),
    .shift (pop),
    .din   (head),
    .dout  (bit_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start_i)                              err_q <= 1'b0;
    else if (load && mode == MODE_DBPSK && delta[0])    err_q <= 1'b1;
  end

  assign odd_err_o = err_q;
endmodule

// File: rtl/dpsk_bit_recover_chk.sv
module dpsk_bit_recover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       mode_qpsk_i,
  input logic       sym_valid_i,
  input logic [1:0] sym_phase_i,
  input logic       sym_ready_o,
  input logic       bit_valid_o,
  input logic       bit_data_o,
  input logic       bit_ready_i,
  input logic       odd_err_o
);
  logic       have_ref_m;
  logic [1:0] prev_m;
  logic       acc;

  assign acc = sym_valid_i && sym_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      have_ref_m <= 1'b0;
      prev_m     <= '0;
    end else if (acc) begin
      have_ref_m <= 1'b1;
      prev_m     <= sym_phase_i;
    end
  end

  // R9
  no_take_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> !sym_ready_o);

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_o && !bit_ready_i && !start_i) |=> (bit_valid_o && $stable(bit_data_o)));

  // R10
  start_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!bit_valid_o && !odd_err_o));

  // R10
  start_blocks_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !sym_ready_o);

  // R6
  reference_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !have_ref_m) |=> !bit_valid_o);

  // R1
  symbol_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && have_ref_m) |=> bit_valid_o);

  // R5
  odd_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && have_ref_m && !mode_qpsk_i && (sym_phase_i[0] ^ prev_m[0])) |=> odd_err_o);

  // R5
  odd_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_err_o && !start_i) |=> odd_err_o);
endmodule

bind dpsk_bit_recover dpsk_bit_recover_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .mode_qpsk_i (mode_qpsk_i),
  .sym_valid_i (sym_valid_i),
  .sym_phase_i (sym_phase_i),
  .sym_ready_o (sym_ready_o),
  .bit_valid_o (bit_valid_o),
  .bit_data_o  (bit_data_o),
  .bit_ready_i (bit_ready_i),
  .odd_err_o   (odd_err_o)
);

// File: tb/dpsk_bit_recover_tb_top.sv
`timescale 1ns/1ps
module dpsk_bit_recover_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       mode_qpsk_i = 1'b0;
  logic       rot_rev_i = 1'b0;
  logic       sym_valid_i = 1'b0;
  logic [1:0] sym_phase_i = 2'd0;
  logic       bit_ready_i = 1'b1;
  logic       sym_ready_o, bit_valid_o, bit_data_o, odd_err_o;

  int n_chk = 0;
  int n_bad = 0;
  int bp_mode = 0;   // 0: always ready, 1: random stalls, 2: held off
  logic cap[$];
  logic expq[$];
  logic [1:0] ph[$];

  always #4 clk = ~clk;

  dpsk_bit_recover dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_qpsk_i(mode_qpsk_i),
    .rot_rev_i(rot_rev_i), .sym_valid_i(sym_valid_i), .sym_phase_i(sym_phase_i),
    .sym_ready_o(sym_ready_o), .bit_valid_o(bit_valid_o), .bit_data_o(bit_data_o),
    .bit_ready_i(bit_ready_i), .odd_err_o(odd_err_o)
  );

  // Ready is set on the falling edge; the transfer seen by the next rising edge is recorded.
  always @(negedge clk) begin
    bit_ready_i <= (bp_mode == 0) ? 1'b1 : (bp_mode == 2) ? 1'b0 : ($urandom % 3 != 0);
    #1;
    if (rst_n && bit_valid_o && bit_ready_i) cap.push_back(bit_data_o);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic send_sym(input logic [1:0] q);
    @(negedge clk);
    sym_valid_i = 1'b1; sym_phase_i = q;
    #2;
    while (!sym_ready_o) begin @(negedge clk); #2; end
    @(negedge clk);
    sym_valid_i = 1'b0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  function automatic logic [1:0] pair_of(input logic [1:0] d);
    case (d)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  // Expected stream from the requirements (R1, R3, R4, R6, R7).
  task automatic build_exp(input logic qpsk, input logic rev);
    logic raw[$];
    logic h[7];
    for (int i = 0; i < 7; i++) h[i] = 1'b0;
    expq.delete();
    for (int i = 1; i < ph.size(); i++) begin
      logic [1:0] d;
      d = rev ? ph[i-1] - ph[i] : ph[i] - ph[i-1];
      if (qpsk) begin
        logic [1:0] p;
        p = pair_of(d);
        raw.push_back(p[1]); raw.push_back(p[0]);
      end else raw.push_back(d[1]);
    end
    foreach (raw[i]) begin
      expq.push_back(raw[i] ^ h[3] ^ h[6]);
      for (int k = 6; k > 0; k--) h[k] = h[k-1];
      h[0] = raw[i];
    end
  endtask

  task automatic run_stream(input logic qpsk, input logic rev);
    @(negedge clk); mode_qpsk_i = qpsk; rot_rev_i = rev;
    pulse_start();
    cap.delete();
    foreach (ph[i]) send_sym(ph[i]);
    drain();
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R11", "bit_valid after reset", bit_valid_o, 0);
    chk("R11", "sym_ready after reset", sym_ready_o, 1);
    chk("R11", "odd_err after reset", odd_err_o, 0);
  endtask

  task automatic t_qpsk_table(input logic rev);
    for (int d = 0; d < 4; d++) begin
      logic [1:0] p, q1;
      q1 = rev ? 2'(1 - d) : 2'(1 + d);
      ph.delete(); ph.push_back(2'd1); ph.push_back(q1);
      run_stream(1'b1, rev);
      p = pair_of(2'(d));
      chk(rev ? "R3" : "R1", "pair bit count", cap.size(), 2);
      if (cap.size() == 2) begin
        chk(rev ? "R3" : "R2", "first bit of pair", cap[0], p[1]);
        chk(rev ? "R3" : "R1", "second bit of pair", cap[1], p[0]);
      end
    end
  endtask

  task automatic t_bpsk();
    ph.delete();
    ph.push_back(2'd0); ph.push_back(2'd2); ph.push_back(2'd2);
    ph.push_back(2'd0); ph.push_back(2'd0);
    run_stream(1'b0, 1'b0);
    chk("R4", "bpsk bit count", cap.size(), 4);
    if (cap.size() == 4) begin
      chk("R4", "bpsk bit0", cap[0], 1); chk("R4", "bpsk bit1", cap[1], 0);
      chk("R4", "bpsk bit2", cap[2], 1); chk("R4", "bpsk bit3", cap[3], 0);
    end
    chk("R4", "no odd flag on even changes", odd_err_o, 0);
  endtask

  task automatic t_bpsk_odd();
    ph.delete(); ph.push_back(2'd0); ph.push_back(2'd1); ph.push_back(2'd1);
    run_stream(1'b0, 1'b0);
    chk("R5", "odd change bit count", cap.size(), 2);
    if (cap.size() == 2) chk("R5", "odd change bit value", cap[0], 0);
    chk("R5", "odd flag set", odd_err_o, 1);
    repeat (5) @(negedge clk);
    #1 chk("R5", "odd flag sticky", odd_err_o, 1);
    pulse_start();
    #1 chk("R10", "odd flag cleared by start", odd_err_o, 0);
  endtask

  task automatic t_reference();
    ph.delete(); ph.push_back(2'd3);
    run_stream(1'b1, 1'b0);
    chk("R6", "reference symbol emits nothing", cap.size(), 0);
  endtask

  task automatic t_random(input logic qpsk, input int n);
    int bad = 0;
    ph.delete();
    ph.push_back(2'($urandom));
    for (int i = 1; i < n; i++)
      ph.push_back(qpsk ? 2'($urandom) : ph[i-1] + 2'({$urandom % 2, 1'b0}));
    bp_mode = 1;
    run_stream(qpsk, 1'b0);
    repeat (n * 3) @(negedge clk);
    bp_mode = 0;
    build_exp(qpsk, 1'b0);
    chk("R7", "random stream bit count", cap.size(), expq.size());
    foreach (expq[i]) if (i < cap.size() && cap[i] !== expq[i]) bad++;
    chk("R7", "random stream mismatching bits", bad, 0);
  endtask

  task automatic t_error_ext();
    logic a[$], b[$];
    logic bits[40];
    int diffs[$];
    for (int i = 0; i < 40; i++) bits[i] = 1'($urandom);
    for (int pass = 0; pass < 2; pass++) begin
      ph.delete(); ph.push_back(2'd0);
      for (int i = 0; i < 40; i++) begin
        logic bv;
        bv = (pass == 1 && i == 15) ? ~bits[i] : bits[i];
        ph.push_back(ph[i] + {bv, 1'b0});
      end
      run_stream(1'b0, 1'b0);
      if (pass == 0) a = cap; else b = cap;
    end
    chk("R8", "lengths equal", b.size(), a.size());
    foreach (a[i]) if (i < b.size() && a[i] !== b[i]) diffs.push_back(i);
    chk("R8", "number of output errors", diffs.size(), 3);
    if (diffs.size() == 3) begin
      chk("R8", "error at k", diffs[0], 15);
      chk("R8", "error at k+4", diffs[1], 19);
      chk("R8", "error at k+7", diffs[2], 22);
    end
  endtask

  task automatic t_backpressure();
    logic d0;
    @(negedge clk); mode_qpsk_i = 1'b1; rot_rev_i = 1'b0;
    pulse_start();
    cap.delete();
    bp_mode = 2;
    send_sym(2'd0);
    send_sym(2'd2);            // delta 2: pair 11
    #2;
    d0 = bit_data_o;
    for (int i = 0; i < 4; i++) begin
      chk("R9", "valid held while stalled", bit_valid_o, 1);
      chk("R9", "ready low while pending", sym_ready_o, 0);
      chk("R9", "data held while stalled", bit_data_o, d0);
      @(negedge clk); #2;
    end
    bp_mode = 0;
    drain();
    chk("R9", "bits delivered after stall", cap.size(), 2);
  endtask

  task automatic t_start_flush();
    bp_mode = 2;
    @(negedge clk); mode_qpsk_i = 1'b1;
    pulse_start();
    send_sym(2'd0);
    send_sym(2'd1);
    @(negedge clk);
    start_i = 1'b1; sym_valid_i = 1'b1; sym_phase_i = 2'd3;
    #2 chk("R10", "ready low during start", sym_ready_o, 0);
    @(negedge clk);
    start_i = 1'b0; sym_valid_i = 1'b0;
    #2 chk("R10", "pending bits discarded", bit_valid_o, 0);
    bp_mode = 0;
    cap.delete();
    send_sym(2'd2);             // new reference after start
    drain();
    chk("R10", "symbol after start is reference", cap.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_qpsk_table(1'b0);
    t_qpsk_table(1'b1);
    t_bpsk();
    t_bpsk_odd();
    t_reference();
    t_random(1'b1, 60);
    t_random(1'b0, 50);
    t_error_ext();
    t_backpressure();
    t_start_flush();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule